// File: doc/BRIEF.md
# Fractional Audio Event Scheduler

This block decides, once per 8 kHz isochronous cycle, how many audio events go into the next outgoing packet. The sample rate is always a whole number of hertz, so it keeps the samples that become available each cycle as an exact fraction over 8000. A running leftover fraction carries what was not sent from one cycle to the next. In non-blocking mode every whole available sample is sent. In blocking mode a packet carries either one full timestamp block or nothing. For each packet it also forms a 16-bit synchronization timestamp and keeps an 8-bit data block counter.

Packets leave on a valid/ready interface. A packet descriptor stays on the outputs, unchanged, until the consumer accepts it. A cycle tick that arrives while a descriptor is still waiting is skipped: no packet is made and no state moves, which is what happens when the sample buffer is short. Configuration is a pulse with a rate code and a mode bit. It reloads every accumulator and drops any waiting descriptor. An unknown rate code leaves the block idle with an error flag set.

Top module: `audio_evt_sched`

## Requirements
- R1: After synchronous reset `out_valid`, `cfg_active` and `cfg_error` are 0, and no packet appears until a valid configuration is loaded.
- R2: Rate codes 0..6 select 32000, 44100, 48000, 88200, 96000, 176400 and 192000 Hz. Loading code 7 sets `cfg_error`=1 and `cfg_active`=0, and cycle ticks then produce no packet. A valid load clears `cfg_error` and sets `cfg_active`.
- R3: On each tick, available = leftover + rate/8000, held as an integer plus a numerator over 8000. In non-blocking mode (`cfg_blocking`=0) the event count is floor(available).
- R4: In blocking mode the event count is the block length when floor(available) is at least the block length, and 0 otherwise. A 0-event packet is still emitted. The block length is 8 for codes 0..2, 16 for codes 3..4 and 32 for codes 5..6.
- R5: A packet is emitted only when `fill_events` >= event count. After an emitted packet the leftover becomes available minus the event count, keeping the fraction. When the buffer is short, no packet appears and the leftover is unchanged.
- R6: A packet appears on the outputs in the clock after the tick. While `out_valid`=1 and `out_ready`=0 all output fields hold steady, and a tick in that state is skipped with no state change.
- R7: `out_dbc` is the 8-bit sum, modulo 256, of the event counts of all earlier packets since configuration. It starts at 0.
- R8: Let idx = (L − dbc) & (L − 1), with L the block length and dbc the packet's `out_dbc`. If idx < event count, `out_stamp` = {cycle[3:0], offset[11:0]}. Otherwise `out_stamp` = 16'hFFFF.
- R9: After each packet that carries a timestamp, the offset grows by 24576000·L/rate ticks, kept exactly as a fraction over the rate. Each whole 3072 ticks of offset moves into the cycle count (mod 16). The offset integer stays below 3072.
- R10: Configuration presets the cycle count to 2 and the offset to 2856 (a 9000-tick delay). It also clears the leftover and the data block counter and drops a waiting packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Configuration pulse |
| cfg_rate | input | 3 | Rate code, 0..6 valid |
| cfg_blocking | input | 1 | 1 = blocking mode |
| cyc_tick | input | 1 | One pulse per isochronous cycle |
| fill_events | input | 8 | Whole events currently buffered |
| out_valid | output | 1 | Packet descriptor valid |
| out_ready | input | 1 | Consumer accepts the descriptor |
| out_events | output | 8 | Event count of the packet |
| out_stamp | output | 16 | Synchronization timestamp or 16'hFFFF |
| out_dbc | output | 8 | Data block count of the packet's first event |
| cfg_active | output | 1 | A valid configuration is loaded |
| cfg_error | output | 1 | The last configuration had an unknown rate code |

## Verification
The bench goes after the 44.1 kHz family, where the 41/80 fraction must carry a whole sample every few cycles. A design that dropped the numerator would send five events per cycle where six are due. The bench starves the buffer at random and stalls the consumer during ticks. A design that updated the leftover or the counter on a skipped tick would drift away from the model on the next packet. Blocking mode at 192 kHz tests whether empty packets are emitted at all. The dbc wrap at 256 and the change of timestamp index across the three block lengths test the modulo index: a wrong mask would stamp the wrong packets. Reconfiguring mid-stream and loading the unknown rate code test the preset of 2 cycles and 2856 ticks, and the idle state.

// File: rtl/aes_pkg.sv
package aes_pkg;
  localparam int NUM_RATES       = 7;
  localparam int CODE_W          = 3;
  localparam int CYCLE_HZ        = 8000;
  localparam int TICK_HZ         = 24576000;
  localparam int TICKS_PER_CYCLE = 3072;
  localparam int XFER_DELAY      = 9000;
  localparam int EV_W            = 8;
  localparam int SPC_INT_W       = 6;
  localparam int SPC_NUM_W       = $clog2(CYCLE_HZ);
  localparam int RATE_W          = 18;
  localparam int OFF_W           = $clog2(TICKS_PER_CYCLE);
  localparam int TQ_INT_W        = 14;
  localparam int SYT_W           = 6;
  localparam int CYC_W           = 16 - OFF_W;

  function automatic int rate_hz(input int code);
    case (code)
      0: return 32000;
      1: return 44100;
      2: return 48000;
      3: return 88200;
      4: return 96000;
      5: return 176400;
      default: return 192000;
    endcase
  endfunction

  function automatic int block_len(input int code);
    if (code < 3) return 8;
    else if (code < 5) return 16;
    else return 32;
  endfunction

  typedef struct packed {
    logic [SPC_INT_W-1:0] spc_int;
    logic [SPC_NUM_W-1:0] spc_num;
    logic [SYT_W-1:0]     syt;
    logic [TQ_INT_W-1:0]  tq_int;
    logic [RATE_W-1:0]    tq_num;
    logic [RATE_W-1:0]    rate;
  } rate_cfg_t;
endpackage

// File: rtl/aes_rate_table.sv
module aes_rate_table
  import aes_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  output rate_cfg_t         cfg
);
  rate_cfg_t tbl [0:NUM_RATES-1];

  for (genvar g = 0; g < NUM_RATES; g++) begin : g_rate
    localparam int R  = rate_hz(g);
    localparam int S  = block_len(g);
    localparam int TQ = TICK_HZ * S;
    assign tbl[g].spc_int = SPC_INT_W'(R / CYCLE_HZ);
    assign tbl[g].spc_num = SPC_NUM_W'(R % CYCLE_HZ);
    assign tbl[g].syt     = SYT_W'(S);
    assign tbl[g].tq_int  = TQ_INT_W'(TQ / R);
    assign tbl[g].tq_num  = RATE_W'(TQ % R);
    assign tbl[g].rate    = RATE_W'(R);
  end

  always_comb begin
    cfg = '0;
    for (int i = 0; i < NUM_RATES; i++)
      if (int'(code) == i) cfg = tbl[i];
  end
endmodule

// File: rtl/aes_event_count.sv
module aes_event_count
  import aes_pkg::*;
(
  input  logic                 clk,
  input  logic                 clear,
  input  logic                 commit,
  input  logic                 blocking,
  input  logic [SPC_INT_W-1:0] spc_int,
  input  logic [SPC_NUM_W-1:0] spc_num,
  input  logic [SYT_W-1:0]     syt,
  output logic [EV_W-1:0]      events
);
  localparam logic [SPC_NUM_W:0] DEN = (SPC_NUM_W+1)'(CYCLE_HZ);

  logic [EV_W-1:0]      left_int_q;
  logic [SPC_NUM_W-1:0] left_num_q;
  logic [SPC_NUM_W:0]   sum_num;
  logic                 wrap;
  logic [SPC_NUM_W-1:0] avail_num;
  logic [EV_W-1:0]      avail_int;
  logic [EV_W-1:0]      blk_len;

  always_comb begin
    sum_num   = {1'b0, left_num_q} + {1'b0, spc_num};
    wrap      = sum_num >= DEN;
    avail_num = wrap ? SPC_NUM_W'(sum_num - DEN) : sum_num[SPC_NUM_W-1:0];
    avail_int = left_int_q + EV_W'(spc_int) + EV_W'(wrap);
    blk_len   = EV_W'(syt);
    if (blocking)
      events = (avail_int >= blk_len) ? blk_len : '0;
    else
      events = avail_int;
  end

  always_ff @(posedge clk) begin
    if (clear) begin
      left_int_q <= '0;
      left_num_q <= '0;
    end else if (commit) begin
      left_int_q <= avail_int - events;
      left_num_q <= avail_num;
    end
  end
endmodule

// File: rtl/aes_stamp.sv
module aes_stamp
  import aes_pkg::*;
(
  input  logic                clk,
  input  logic                clear,
  input  logic                commit,
  input  logic [EV_W-1:0]     events,
  input  logic [EV_W-1:0]     dbc,
  input  logic [SYT_W-1:0]    syt,
  input  logic [TQ_INT_W-1:0] tq_int,
  input  logic [RATE_W-1:0]   tq_num,
  input  logic [RATE_W-1:0]   rate,
  output logic [15:0]         stamp
);
  localparam int SUM_W = TQ_INT_W + 1;
  localparam logic [SUM_W-1:0] TPC = SUM_W'(TICKS_PER_CYCLE);
  localparam logic [CYC_W-1:0] CYC_INIT = CYC_W'(XFER_DELAY / TICKS_PER_CYCLE);
  localparam logic [OFF_W-1:0] OFF_INIT = OFF_W'(XFER_DELAY % TICKS_PER_CYCLE);
  localparam int MAX_CARRY = 4;

  logic [CYC_W-1:0]  cyc_q;
  logic [OFF_W-1:0]  off_int_q;
  logic [RATE_W-1:0] off_num_q;

  logic [EV_W-1:0]   blk_len;
  logic [EV_W-1:0]   idx;
  logic              has_stamp;
  logic [RATE_W:0]   sum_num;
  logic              num_carry;
  logic [RATE_W-1:0] nxt_num;
  logic [SUM_W-1:0]  sum_int;
  logic [CYC_W-1:0]  cyc_add;

  always_comb begin
    blk_len   = EV_W'(syt);
    idx       = (blk_len - dbc) & (blk_len - EV_W'(1));
    has_stamp = idx < events;
    stamp     = has_stamp ? {cyc_q, off_int_q} : 16'hFFFF;
  end

  always_comb begin
    sum_num   = {1'b0, off_num_q} + {1'b0, tq_num};
    num_carry = sum_num >= {1'b0, rate};
    nxt_num   = num_carry ? RATE_W'(sum_num - {1'b0, rate}) : sum_num[RATE_W-1:0];
    sum_int   = SUM_W'(off_int_q) + SUM_W'(tq_int) + SUM_W'(num_carry);
    cyc_add   = '0;
    for (int i = 0; i < MAX_CARRY; i++) begin
      if (sum_int >= TPC) begin
        sum_int = sum_int - TPC;
        cyc_add = cyc_add + CYC_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (clear) begin
      cyc_q     <= CYC_INIT;
      off_int_q <= OFF_INIT;
      off_num_q <= '0;
    end else if (commit && has_stamp) begin
      cyc_q     <= cyc_q + cyc_add;
      off_int_q <= OFF_W'(sum_int);
      off_num_q <= nxt_num;
    end
  end
endmodule

// File: rtl/audio_evt_sched.sv
module audio_evt_sched
  import aes_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_load,
  input  logic [CODE_W-1:0] cfg_rate,
  input  logic              cfg_blocking,
  input  logic              cyc_tick,
  input  logic [EV_W-1:0]   fill_events,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [EV_W-1:0]   out_events,
  output logic [15:0]       out_stamp,
  output logic [EV_W-1:0]   out_dbc,
  output logic              cfg_active,
  output logic              cfg_error
);
  logic              active_q, err_q, blk_q;
  logic [CODE_W-1:0] code_q;
  logic [EV_W-1:0]   dbc_q;
  rate_cfg_t         rcfg;
  logic [SYT_W-1:0]  syt_q;
  logic [EV_W-1:0]   events;
  logic [15:0]       stamp;
  logic              stall, fire, clear;

  aes_rate_table u_table (
    .code (code_q),
    .cfg  (rcfg)
  );

  assign syt_q = rcfg.syt;
  assign clear = rst | cfg_load;
  assign stall = out_valid & ~out_ready;
  assign fire  = cyc_tick & active_q & ~cfg_load & ~stall & (fill_events >= events);

  aes_event_count u_count (
    .clk      (clk),
    .clear    (clear),
    .commit   (fire),
    .blocking (blk_q),
    .spc_int  (rcfg.spc_int),
    .spc_num  (rcfg.spc_num),
    .syt      (rcfg.syt),
    .events   (events)
  );

  aes_stamp u_stamp (
    .clk    (clk),
    .clear  (clear),
    .commit (fire),
    .events (events),
    .dbc    (dbc_q),
    .syt    (rcfg.syt),
    .tq_int (rcfg.tq_int),
    .tq_num (rcfg.tq_num),
    .rate   (rcfg.rate),
    .stamp  (stamp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q   <= 1'b0;
      err_q      <= 1'b0;
      blk_q      <= 1'b0;
      code_q     <= '0;
      dbc_q      <= '0;
      out_valid  <= 1'b0;
      out_events <= '0;
      out_stamp  <= '0;
      out_dbc    <= '0;
    end else if (cfg_load) begin
      active_q  <= int'(cfg_rate) < NUM_RATES;
      err_q     <= int'(cfg_rate) >= NUM_RATES;
      blk_q     <= cfg_blocking;
      code_q    <= cfg_rate;
      dbc_q     <= '0;
      out_valid <= 1'b0;
    end else if (fire) begin
      out_valid  <= 1'b1;
      out_events <= events;
      out_stamp  <= stamp;
      out_dbc    <= dbc_q;
      dbc_q      <= dbc_q + events;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assign cfg_active = active_q;
  assign cfg_error  = err_q;
endmodule

// File: rtl/aes_sched_chk.sv
module aes_sched_chk
  import aes_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             cfg_load,
  input logic             cfg_active,
  input logic             cfg_error,
  input logic             out_valid,
  input logic             out_ready,
  input logic [EV_W-1:0]  out_events,
  input logic [15:0]      out_stamp,
  input logic [EV_W-1:0]  out_dbc,
  input logic             blk_q,
  input logic [SYT_W-1:0] syt_q
);
  logic [EV_W-1:0] dbc_exp;

  always_ff @(posedge clk) begin
    if (rst || cfg_load) dbc_exp <= '0;
    else if (out_valid && out_ready) dbc_exp <= out_dbc + out_events;
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && !cfg_active && !cfg_error));

  // R2
  idle_no_packet_chk: assert property (@(posedge clk) disable iff (rst)
    (!cfg_active && !cfg_load) |=> !$rose(out_valid));

  // R4
  block_size_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && blk_q) |-> (out_events == '0 || out_events == EV_W'(syt_q)));

  // R6
  hold_stalled_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready && !cfg_load) |=>
      (out_valid && $stable(out_events) && $stable(out_stamp) && $stable(out_dbc)));

  // R7
  dbc_running_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_dbc == dbc_exp);

  // R8
  stamp_needs_event_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_stamp != 16'hFFFF) |-> out_events != '0);

  // R9
  offset_range_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_stamp != 16'hFFFF) |-> int'(out_stamp[11:0]) < TICKS_PER_CYCLE);
endmodule

bind audio_evt_sched aes_sched_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .cfg_load   (cfg_load),
  .cfg_active (cfg_active),
  .cfg_error  (cfg_error),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_events (out_events),
  .out_stamp  (out_stamp),
  .out_dbc    (out_dbc),
  .blk_q      (blk_q),
  .syt_q      (syt_q)
);

// File: tb/tb_audio_evt_sched.sv
module tb_audio_evt_sched;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_load = 1'b0;
  logic [2:0] cfg_rate = '0;
  logic       cfg_blocking = 1'b0;
  logic       cyc_tick = 1'b0;
  logic [7:0] fill_events = '0;
  logic       out_valid;
  logic       out_ready = 1'b0;
  logic [7:0] out_events;
  logic [15:0] out_stamp;
  logic [7:0] out_dbc;
  logic       cfg_active, cfg_error;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  int m_lo_int, m_lo_num, m_dbc, m_cyc, m_off_int, m_off_num, m_code;
  bit m_blk, m_active;

  always #5 clk = ~clk;

  audio_evt_sched dut (
    .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_rate(cfg_rate),
    .cfg_blocking(cfg_blocking), .cyc_tick(cyc_tick), .fill_events(fill_events),
    .out_valid(out_valid), .out_ready(out_ready), .out_events(out_events),
    .out_stamp(out_stamp), .out_dbc(out_dbc), .cfg_active(cfg_active),
    .cfg_error(cfg_error)
  );

  function automatic int rate_of(input int c);
    case (c)
      0: return 32000;  1: return 44100;  2: return 48000;
      3: return 88200;  4: return 96000;  5: return 176400;
      default: return 192000;
    endcase
  endfunction

  function automatic int syt_of(input int c);
    return (c <= 2) ? 8 : (c <= 4) ? 16 : 32;
  endfunction

  task automatic check(input string req, input int got, input int exp);
    n_checks++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s got %0d (0x%0h) expected %0d (0x%0h)", req, got, got, exp, exp);
    end
  endtask

  task automatic configure(input int code, input bit blk);
    @(negedge clk);
    cfg_load = 1'b1; cfg_rate = 3'(code); cfg_blocking = blk;
    @(negedge clk);
    cfg_load = 1'b0;
    m_active = code < 7; m_code = code; m_blk = blk;
    m_lo_int = 0; m_lo_num = 0; m_dbc = 0;
    m_cyc = 2; m_off_int = 2856; m_off_num = 0;
    check("R2 cfg_active", int'(cfg_active), int'(m_active));
    check("R2 cfg_error", int'(cfg_error), int'(!m_active));
    check("R10 no packet after configure", int'(out_valid), 0);
  endtask

  // Model one tick; returns whether a packet is expected and its fields.
  task automatic model_tick(input int fill, output bit pkt, output int ev,
                            output int st, output int db);
    int num, whole, syt, rate, idx, tq, on, oi;
    pkt = 1'b0; ev = 0; st = 0; db = 0;
    if (!m_active) return;
    rate  = rate_of(m_code);
    syt   = syt_of(m_code);
    num   = m_lo_num + (rate % 8000);
    whole = m_lo_int + rate / 8000 + (num >= 8000 ? 1 : 0);
    num   = num % 8000;
    ev    = m_blk ? ((whole >= syt) ? syt : 0) : whole;
    if (fill < ev) return;
    pkt = 1'b1;
    db  = m_dbc;
    idx = (syt - m_dbc) & (syt - 1);
    if (idx < ev) begin
      st = ((m_cyc << 12) | m_off_int) & 16'hFFFF;
      tq = 24576000 * syt;
      on = m_off_num + tq % rate;
      oi = m_off_int + tq / rate + (on >= rate ? 1 : 0);
      m_off_num = on % rate;
      m_cyc = (m_cyc + oi / 3072) % 16;
      m_off_int = oi % 3072;
    end else begin
      st = 16'hFFFF;
    end
    m_dbc = (m_dbc + ev) % 256;
    m_lo_int = whole - ev;
    m_lo_num = num;
  endtask

  // One tick with the consumer ready afterwards; optional stall test.
  task automatic do_tick(input int fill, input bit stall_test);
    bit pkt; int ev, st, db;
    model_tick(fill, pkt, ev, st, db);
    @(negedge clk);
    cyc_tick = 1'b1; fill_events = 8'(fill);
    @(negedge clk);
    cyc_tick = 1'b0;
    if (!pkt) begin
      check(m_active ? "R5 short buffer no packet" : "R2 idle no packet", int'(out_valid), 0);
      return;
    end
    check("R6 packet valid", int'(out_valid), 1);
    check(m_blk ? "R4 blocking events" : "R3 nonblocking events", int'(out_events), ev);
    check("R8 R9 timestamp", int'(out_stamp), st);
    check("R7 dbc", int'(out_dbc), db);
    if (stall_test) begin
      cyc_tick = 1'b1; fill_events = 8'd255;
      @(negedge clk);
      cyc_tick = 1'b0;
      @(negedge clk);
      check("R6 stall holds valid", int'(out_valid), 1);
      check("R6 stall holds events", int'(out_events), ev);
      check("R6 stall holds stamp", int'(out_stamp), st);
    end
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    check("R6 accepted", int'(out_valid), 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    m_active = 1'b0; m_code = 0; m_blk = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 out_valid", int'(out_valid), 0);
    check("R1 cfg_active", int'(cfg_active), 0);
    check("R1 cfg_error", int'(cfg_error), 0);
    do_tick(255, 1'b0);

    // Directed: 44.1 kHz non-blocking fraction carry (R3)
    configure(1, 1'b0);
    for (int i = 0; i < 40; i++) do_tick(255, 1'b0);
    // Starved buffer leaves leftover unchanged (R5)
    do_tick(0, 1'b0);
    do_tick(3, 1'b0);
    do_tick(255, 1'b1);
    // Blocking at 192 kHz with empty packets (R4)
    configure(6, 1'b1);
    for (int i = 0; i < 20; i++) do_tick(255, 1'b0);
    // Unknown code (R2)
    configure(7, 1'b0);
    do_tick(255, 1'b0);
    // Mid-stream reconfigure presets (R10)
    configure(2, 1'b0);
    do_tick(255, 1'b0);
    // Long run to wrap dbc (R7) at 96 kHz
    configure(4, 1'b0);
    for (int i = 0; i < 60; i++) do_tick(255, 1'b0);

    // Random mix
    for (int i = 0; i < 2500; i++) begin
      if ($urandom % 80 == 0)
        configure(int'($urandom % 8), 1'($urandom % 2));
      do_tick(($urandom % 4 == 0) ? int'($urandom % 40) : 255, ($urandom % 10) == 0);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule